// File: doc/BRIEF.md
# Audio Serial FIFO Interrupt Aggregator

This block builds the single interrupt line of a three-channel stereo audio serial-port controller. It watches the level flags of the transmit and receive FIFOs of every channel and turns them into per-channel threshold sources. It also keeps one transmit underflow source and one receive overflow source. The gated transmit and receive interrupts are then merged into one output.

A threshold source follows the FIFO level directly. It is suppressed while its channel is disabled. A control bit selects the threshold: the fully empty (or fully full) flag, or the half flag. The underflow and overflow sources work differently. Once set, each one stays set until software has serviced every enabled channel on that side, meaning it has accessed both the left and the right data register of each such channel. It also clears if a channel on that side is switched off.

The block also keeps six sticky status bits, one per channel and side, recording underflow and overflow events. Software clears a sticky bit by writing zero to it. The receive FIFO-empty flags are reported as plain status and never raise an interrupt. The FIFOs, the serial shifters and the bus decode are outside this block. FIFO flags and register-access strobes arrive as inputs.

Top module: `audio_irq_agg`

## Requirements
- R1: After reset, with all inputs low, every source, sticky bit, status bit and interrupt output is 0.
- R2: Transmit source bit i (i = 0..2) equals tx_ch_en[i] AND (tx_lvl_empty[i] when tx_thr_full = 1, otherwise tx_lvl_half[i]). The source follows the flags in the same cycle.
- R3: tx_irq is 1 exactly when tx_irq_en = 1 and any of the four transmit source bits is 1.
- R4: A tx_urun pulse on an enabled channel sets transmit source bit 3 (underflow) at the next clock edge. A pulse on a disabled channel has no effect.
- R5: Underflow clears at the clock edge where, for every enabled transmit channel, both a tx_wr_l and a tx_wr_r strobe have been seen since the underflow was set. Strobes present in that same cycle count. Strobes from before the set do not count.
- R6: While underflow is pending, a 1-to-0 transition of any tx_ch_en bit clears it at the next edge. A new underflow event in the same cycle takes priority and keeps it set.
- R7: Receive source bit i equals rx_ch_en[i] AND (rx_lvl_full[i] when rx_thr_full = 1, otherwise rx_lvl_half[i]). rx_irq is 1 exactly when rx_irq_en = 1 and any of the four receive source bits is 1.
- R8: Receive source bit 3 (overflow) is set the edge after an rx_orun pulse on an enabled channel. It clears once both rx_rd_l and rx_rd_r have been seen for every enabled receive channel, or when an rx_ch_en bit falls, with the same timing and priority rules as R5 and R6.
- R9: irq is 1 exactly when tx_irq or rx_irq is 1.
- R10: rx_empty_sts[i] equals rx_lvl_empty[i] AND rx_ch_en[i]. It has no effect on any source or interrupt.
- R11: Sticky bit i (0..2) is set by an underflow event on enabled transmit channel i. Sticky bit 3+i is set by an overflow event on enabled receive channel i. On a cycle with sts_wr = 1, a bit written 0 clears and a bit written 1 is unchanged. A set event in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_thr_full | input | 1 | Transmit threshold: 1 = fully empty, 0 = half empty |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_thr_full | input | 1 | Receive threshold: 1 = full, 0 = half full |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_ch_en | input | 3 | Transmit channel enables |
| rx_ch_en | input | 3 | Receive channel enables |
| tx_lvl_empty | input | 3 | Transmit FIFO empty flags |
| tx_lvl_half | input | 3 | Transmit FIFO half-empty flags |
| rx_lvl_full | input | 3 | Receive FIFO full flags |
| rx_lvl_half | input | 3 | Receive FIFO half-full flags |
| rx_lvl_empty | input | 3 | Receive FIFO empty flags |
| tx_urun | input | 3 | Per-channel transmit underflow event pulses |
| rx_orun | input | 3 | Per-channel receive overflow event pulses |
| tx_wr_l | input | 3 | Left transmit data register write strobes |
| tx_wr_r | input | 3 | Right transmit data register write strobes |
| rx_rd_l | input | 3 | Left receive data register read strobes |
| rx_rd_r | input | 3 | Right receive data register read strobes |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 6 | Status write data for the sticky bits |
| tx_src | output | 4 | Transmit sources: [2:0] channel FIFO-empty, [3] underflow |
| rx_src | output | 4 | Receive sources: [2:0] channel FIFO-full, [3] overflow |
| sticky | output | 6 | Sticky bits: [2:0] underflow per channel, [5:3] overflow per channel |
| rx_empty_sts | output | 3 | Receive FIFO empty status, no interrupt |
| tx_irq | output | 1 | Gated transmit interrupt |
| rx_irq | output | 1 | Gated receive interrupt |
| irq | output | 1 | Combined controller interrupt |

## Verification
Random stimulus flips the threshold selects, the enables and the level flags. This separates the half-level path from the full-level path, and it shows whether a disabled channel is really masked. Long runs of sparse access strobes mixed with underflow and overflow events test the seen-flag tracking. Only a complete left and right set over the enabled channels may clear a pending condition, and strobes that come before the event must not count. Directed cases cover four situations: the last missing strobe clears the condition in its own cycle, a disable clears a pending condition, a set event collides with a clear, and a sticky-bit write with ones leaves the bits alone.

// File: rtl/audio_irq_agg.sv
module audio_irq_agg #(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_thr_full,
  input  logic             tx_irq_en,
  input  logic             rx_thr_full,
  input  logic             rx_irq_en,
  input  logic [NCH-1:0]   tx_ch_en,
  input  logic [NCH-1:0]   rx_ch_en,
  input  logic [NCH-1:0]   tx_lvl_empty,
  input  logic [NCH-1:0]   tx_lvl_half,
  input  logic [NCH-1:0]   rx_lvl_full,
  input  logic [NCH-1:0]   rx_lvl_half,
  input  logic [NCH-1:0]   rx_lvl_empty,
  input  logic [NCH-1:0]   tx_urun,
  input  logic [NCH-1:0]   rx_orun,
  input  logic [NCH-1:0]   tx_wr_l,
  input  logic [NCH-1:0]   tx_wr_r,
  input  logic [NCH-1:0]   rx_rd_l,
  input  logic [NCH-1:0]   rx_rd_r,
  input  logic             sts_wr,
  input  logic [2*NCH-1:0] sts_wdata,
  output logic [NCH:0]     tx_src,
  output logic [NCH:0]     rx_src,
  output logic [2*NCH-1:0] sticky,
  output logic [NCH-1:0]   rx_empty_sts,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             irq
);

  logic           tx_pend, rx_pend;
  logic [NCH-1:0] tx_seen_l, tx_seen_r, rx_seen_l, rx_seen_r;
  logic [NCH-1:0] tx_en_q, rx_en_q;

  wire tx_set  = |(tx_urun & tx_ch_en);
  wire rx_set  = |(rx_orun & rx_ch_en);
  wire tx_drop = |(tx_en_q & ~tx_ch_en);
  wire rx_drop = |(rx_en_q & ~rx_ch_en);
  wire tx_done = &(((tx_seen_l | tx_wr_l) & (tx_seen_r | tx_wr_r)) | ~tx_ch_en);
  wire rx_done = &(((rx_seen_l | rx_rd_l) & (rx_seen_r | rx_rd_r)) | ~rx_ch_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_pend   <= 1'b0;
      tx_seen_l <= '0;
      tx_seen_r <= '0;
      tx_en_q   <= '0;
    end else begin
      tx_en_q <= tx_ch_en;
      if (tx_set) begin
        tx_pend   <= 1'b1;
        tx_seen_l <= '0;
        tx_seen_r <= '0;
      end else if (tx_pend && (tx_done || tx_drop)) begin
        tx_pend   <= 1'b0;
        tx_seen_l <= '0;
        tx_seen_r <= '0;
      end else if (tx_pend) begin
        tx_seen_l <= (tx_seen_l | tx_wr_l) & tx_ch_en;
        tx_seen_r <= (tx_seen_r | tx_wr_r) & tx_ch_en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pend   <= 1'b0;
      rx_seen_l <= '0;
      rx_seen_r <= '0;
      rx_en_q   <= '0;
    end else begin
      rx_en_q <= rx_ch_en;
      if (rx_set) begin
        rx_pend   <= 1'b1;
        rx_seen_l <= '0;
        rx_seen_r <= '0;
      end else if (rx_pend && (rx_done || rx_drop)) begin
        rx_pend   <= 1'b0;
        rx_seen_l <= '0;
        rx_seen_r <= '0;
      end else if (rx_pend) begin
        rx_seen_l <= (rx_seen_l | rx_rd_l) & rx_ch_en;
        rx_seen_r <= (rx_seen_r | rx_rd_r) & rx_ch_en;
      end
    end
  end

  wire [2*NCH-1:0] stk_set  = {rx_orun & rx_ch_en, tx_urun & tx_ch_en};
  wire [2*NCH-1:0] stk_keep = sts_wr ? (sticky & sts_wdata) : sticky;

  always_ff @(posedge clk) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= stk_set | stk_keep;
  end

  assign tx_src       = {tx_pend, tx_ch_en & (tx_thr_full ? tx_lvl_empty : tx_lvl_half)};
  assign rx_src       = {rx_pend, rx_ch_en & (rx_thr_full ? rx_lvl_full : rx_lvl_half)};
  assign rx_empty_sts = rx_lvl_empty & rx_ch_en;
  assign tx_irq       = tx_irq_en & (|tx_src);
  assign rx_irq       = rx_irq_en & (|rx_src);
  assign irq          = tx_irq | rx_irq;

endmodule

// File: rtl/audio_irq_agg_chk.sv
module audio_irq_agg_chk #(
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_irq_en,
  input logic             rx_irq_en,
  input logic [NCH-1:0]   tx_ch_en,
  input logic [NCH-1:0]   rx_ch_en,
  input logic [NCH-1:0]   tx_urun,
  input logic [NCH-1:0]   rx_orun,
  input logic             sts_wr,
  input logic [2*NCH-1:0] sts_wdata,
  input logic [NCH:0]     tx_src,
  input logic [NCH:0]     rx_src,
  input logic [2*NCH-1:0] sticky,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic             irq
);

  a_r4_urun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_urun & tx_ch_en)) |=> tx_src[NCH]);

  a_r8_orun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rx_orun & rx_ch_en)) |=> rx_src[NCH]);

  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_src[NCH] && !(|(tx_urun & tx_ch_en)) && (|($past(tx_ch_en) & ~tx_ch_en)))
    |=> !tx_src[NCH]);

  a_r4_no_spurious_urun: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_src[NCH] && !(|(tx_urun & tx_ch_en))) |=> !tx_src[NCH]);

  a_r3_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_irq_en && tx_src != '0));

  a_r10_empty_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_src == '0) |-> !rx_irq);

  a_r9_combined: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_irq || rx_irq));

  a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr && !(|(tx_urun & tx_ch_en)) && !(|(rx_orun & rx_ch_en)))
    |=> (sticky == $past(sticky)));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_urun & tx_ch_en)) |=> ((sticky[NCH-1:0] & $past(tx_urun & tx_ch_en)) == $past(tx_urun & tx_ch_en)));

endmodule

bind audio_irq_agg audio_irq_agg_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
  .tx_ch_en(tx_ch_en), .rx_ch_en(rx_ch_en), .tx_urun(tx_urun), .rx_orun(rx_orun),
  .sts_wr(sts_wr), .sts_wdata(sts_wdata), .tx_src(tx_src), .rx_src(rx_src),
  .sticky(sticky), .tx_irq(tx_irq), .rx_irq(rx_irq), .irq(irq)
);

// File: tb/audio_irq_agg_test.sv
module audio_irq_agg_test;
  localparam int N = 3;

  logic clk = 0, rst_n = 0;
  logic tx_thr_full, tx_irq_en, rx_thr_full, rx_irq_en;
  logic [N-1:0] tx_ch_en, rx_ch_en, tx_lvl_empty, tx_lvl_half, rx_lvl_full, rx_lvl_half, rx_lvl_empty;
  logic [N-1:0] tx_urun, rx_orun, tx_wr_l, tx_wr_r, rx_rd_l, rx_rd_r;
  logic sts_wr;
  logic [2*N-1:0] sts_wdata;
  logic [N:0] tx_src, rx_src;
  logic [2*N-1:0] sticky;
  logic [N-1:0] rx_empty_sts;
  logic tx_irq, rx_irq, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic m_tp, m_rp;
  logic [N-1:0] m_tsl, m_tsr, m_rsl, m_rsr, m_teq, m_req;
  logic [2*N-1:0] m_stk;

  always #5 clk = ~clk;

  audio_irq_agg #(.NCH(N)) uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    {tx_thr_full, tx_irq_en, rx_thr_full, rx_irq_en} = '0;
    {tx_ch_en, rx_ch_en, tx_lvl_empty, tx_lvl_half, rx_lvl_full, rx_lvl_half, rx_lvl_empty} = '0;
    {tx_urun, rx_orun, tx_wr_l, tx_wr_r, rx_rd_l, rx_rd_r} = '0;
    sts_wr = 0; sts_wdata = '0;
  endtask

  function automatic logic pend_next(logic p, logic set, logic drop, logic dn);
    if (set) return 1'b1;
    if (p && (dn || drop)) return 1'b0;
    return p;
  endfunction

  task automatic mstep();
    logic s, dr, dn, np;
    if (!rst_n) begin
      m_tp = 0; m_rp = 0; m_tsl = 0; m_tsr = 0; m_rsl = 0; m_rsr = 0;
      m_teq = 0; m_req = 0; m_stk = 0;
      return;
    end
    s = |(tx_urun & tx_ch_en); dr = |(m_teq & ~tx_ch_en);
    dn = &(((m_tsl | tx_wr_l) & (m_tsr | tx_wr_r)) | ~tx_ch_en);
    np = pend_next(m_tp, s, dr, dn);
    if (s || !np) begin m_tsl = 0; m_tsr = 0; end
    else begin m_tsl = (m_tsl | tx_wr_l) & tx_ch_en; m_tsr = (m_tsr | tx_wr_r) & tx_ch_en; end
    m_tp = np; m_teq = tx_ch_en;
    s = |(rx_orun & rx_ch_en); dr = |(m_req & ~rx_ch_en);
    dn = &(((m_rsl | rx_rd_l) & (m_rsr | rx_rd_r)) | ~rx_ch_en);
    np = pend_next(m_rp, s, dr, dn);
    if (s || !np) begin m_rsl = 0; m_rsr = 0; end
    else begin m_rsl = (m_rsl | rx_rd_l) & rx_ch_en; m_rsr = (m_rsr | rx_rd_r) & rx_ch_en; end
    m_rp = np; m_req = rx_ch_en;
    m_stk = {rx_orun & rx_ch_en, tx_urun & tx_ch_en} | (sts_wr ? (m_stk & sts_wdata) : m_stk);
  endtask

  task automatic cyc();
    @(posedge clk);
    mstep();
    @(negedge clk);
  endtask

  task automatic cmp();
    logic [N:0] et, er;
    logic eti, eri;
    #1;
    et = {m_tp, tx_ch_en & (tx_thr_full ? tx_lvl_empty : tx_lvl_half)};
    er = {m_rp, rx_ch_en & (rx_thr_full ? rx_lvl_full : rx_lvl_half)};
    eti = tx_irq_en & (|et);
    eri = rx_irq_en & (|er);
    chk("R2/R4/R5/R6 tx_src", tx_src, et);
    chk("R7/R8 rx_src", rx_src, er);
    chk("R3 tx_irq", tx_irq, eti);
    chk("R7 rx_irq", rx_irq, eri);
    chk("R9 irq", irq, eti | eri);
    chk("R10 rx_empty_sts", rx_empty_sts, rx_lvl_empty & rx_ch_en);
    chk("R11 sticky", sticky, m_stk);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_a11d));
    clr_in();
    repeat (3) cyc();
    rst_n = 1;
    #1;
    chk("R1 reset tx_src", tx_src, 0);
    chk("R1 reset rx_src", rx_src, 0);
    chk("R1 reset sticky", sticky, 0);
    chk("R1 reset irq", irq, 0);

    // R5: underflow on ch1 with ch0,ch1 enabled; writes before the event do not count
    tx_ch_en = 3'b011; tx_irq_en = 1; tx_wr_l = 3'b011; tx_wr_r = 3'b011; cmp(); cyc();
    tx_wr_l = 0; tx_wr_r = 0; tx_urun = 3'b010; cmp(); cyc();
    tx_urun = 0; #1; chk("R4 urun set", tx_src[3], 1); chk("R11 sticky bit1", sticky, 6'b000010);
    chk("R3 tx_irq on urun", tx_irq, 1);
    tx_wr_l = 3'b001; tx_wr_r = 3'b001; cmp(); cyc();
    tx_wr_l = 0; tx_wr_r = 0; tx_wr_l = 3'b010; cmp(); cyc();
    tx_wr_l = 0; #1; chk("R5 still pending", tx_src[3], 1);
    tx_wr_r = 3'b010; cmp(); cyc();
    tx_wr_r = 0; #1; chk("R5 cleared on last write", tx_src[3], 0);

    // R6: disable clears; collision with new event keeps it set
    tx_urun = 3'b001; cmp(); cyc(); tx_urun = 0;
    tx_ch_en = 3'b001; tx_urun = 3'b001; cmp(); cyc(); tx_urun = 0;
    #1; chk("R6 set wins over disable", tx_src[3], 1);
    tx_ch_en = 3'b000; cmp(); cyc();
    #1; chk("R6 disable clears", tx_src[3], 0);
    tx_urun = 3'b111; cmp(); cyc(); tx_urun = 0;
    #1; chk("R4 disabled channel ignored", tx_src[3], 0);

    // R11: write ones keeps, write zero clears, set wins
    sts_wr = 1; sts_wdata = 6'b111111; cmp(); cyc();
    #1; chk("R11 write one keeps", sticky, 6'b000011);
    rx_ch_en = 3'b100; rx_orun = 3'b100; sts_wdata = 6'b000000; cmp(); cyc();
    sts_wr = 0; rx_orun = 0; #1;
    chk("R11 clear with set winning", sticky, 6'b100000);
    chk("R8 overflow set", rx_src[3], 1);
    rx_rd_l = 3'b100; rx_rd_r = 3'b100; cmp(); cyc();
    rx_rd_l = 0; rx_rd_r = 0; #1; chk("R8 overflow cleared", rx_src[3], 0);

    // R10: empty flags never raise irq
    rx_irq_en = 1; rx_ch_en = 3'b111; rx_lvl_empty = 3'b111; #1;
    chk("R10 empty status", rx_empty_sts, 3'b111); chk("R10 no irq", irq, 0);
    cmp(); cyc();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tx_thr_full = $urandom_range(1); rx_thr_full = $urandom_range(1);
      tx_irq_en = ($urandom_range(9) != 0); rx_irq_en = ($urandom_range(9) != 0);
      if ($urandom_range(19) == 0) tx_ch_en = N'($urandom);
      if ($urandom_range(19) == 0) rx_ch_en = N'($urandom);
      tx_lvl_empty = N'($urandom); tx_lvl_half = N'($urandom) | tx_lvl_empty;
      rx_lvl_full = N'($urandom); rx_lvl_half = N'($urandom) | rx_lvl_full;
      rx_lvl_empty = N'($urandom) & ~rx_lvl_half;
      tx_urun = ($urandom_range(24) == 0) ? N'($urandom) : '0;
      rx_orun = ($urandom_range(24) == 0) ? N'($urandom) : '0;
      tx_wr_l = N'($urandom) & N'($urandom); tx_wr_r = N'($urandom) & N'($urandom);
      rx_rd_l = N'($urandom) & N'($urandom); rx_rd_r = N'($urandom) & N'($urandom);
      sts_wr = ($urandom_range(14) == 0); sts_wdata = 6'($urandom);
      cmp();
      cyc();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule